// File: doc/BRIEF.md
# Data-Processing ALU with Flags

This block is the arithmetic and logic unit of a RISC-style integer datapath. Each cycle it takes a 4-bit opcode, a first operand from the register file and a second operand that the operand shifter has already prepared. It forms a 32-bit result combinationally. It also raises a destination-write qualifier whenever the operation targets a register.

The four condition flags are negative, zero, carry and overflow. They live in a register inside the block and update at the clock edge. The stored carry feeds the carry-using operations of the next instruction, so wide additions and subtractions can be chained one word at a time. When a logical operation updates the flags, its carry comes from the shifter's carry-out.

Top module: `dp_alu`

## Requirements
- R1: With opcode 4 (add) the result is A+B modulo 2^32. With opcode 5 (add with carry) the result is A+B+C, where C is the stored carry flag.
- R2: With opcode 2 (subtract) the result is A−B. With opcode 6 (subtract with carry) the result is A−B−(1−C).
- R3: With opcode 3 (reverse subtract) the result is B−A. With opcode 7 (reverse subtract with carry) the result is B−A−(1−C).
- R4: When an arithmetic operation updates the flags, C takes the unsigned carry-out for additions. For all subtraction forms, C is 1 when no borrow occurs and 0 when a borrow occurs.
- R5: The logical opcodes give these results: 0 is A AND B, 1 is A XOR B, 12 is A OR B, 14 is A AND NOT B, 13 is B, and 15 is NOT B.
- R6: flags_o is {N,Z,C,V} with N at bit 3. On a flag update, N is result bit 31 and Z is 1 exactly when the result is zero. The new flags appear after the next rising clock edge.
- R7: On an update by an arithmetic operation (opcodes 2–7, 10, 11), V is signed two's-complement overflow. A logical operation leaves V unchanged.
- R8: When a logical operation (opcodes 0, 1, 8, 9, 12–15) updates the flags, C takes sh_carry_i.
- R9: Opcodes other than 8–11 update the flags only when set_flags_i is 1. Otherwise all four flags hold.
- R10: Opcodes 8 (test, A AND B), 9 (test-equivalence, A XOR B), 10 (compare, A−B) and 11 (compare-negative, A+B) always update the flags, whatever set_flags_i is. For these opcodes wr_en_o is 0; for every other opcode it is 1.
- R11: Reset clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand (register value) |
| b_i | input | 32 | Second operand (shifter output) |
| sh_carry_i | input | 1 | Shifter carry-out |
| set_flags_i | input | 1 | Request a flag update |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination register write qualifier |
| flags_o | output | 4 | Registered {N,Z,C,V} |

## Verification
Two functions can fall in the same cycle. A carry-using operation reads the stored carry while the same cycle also writes a new carry. The bench provokes this with back-to-back random carry-using operations and with a four-word 128-bit add chain. Each result is judged against a bench model that holds its own copy of the flags. That model carries the expected carry from one instruction into the next, so a stale carry or a carry that lags by one cycle shows up as a mismatch in a later word.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  function automatic logic op_is_arith(alu_op_e op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN});
  endfunction

  function automatic logic op_is_cmp(alu_op_e op);
    return (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
  endfunction
endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int unsigned DataW = 32
) (
  input  alu_op_e          op_i,
  input  logic [DataW-1:0] a_i,
  input  logic [DataW-1:0] b_i,
  input  logic             c_i,
  output logic [DataW-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MsbIdx = DataW - 1;

  logic [DataW-1:0] x, y;
  logic             cin;
  logic [DataW:0]   wide;

  // all forms reduce to x + y + cin; subtraction via inverted operand
  always_comb begin
    x   = a_i;
    y   = b_i;
    cin = 1'b0;
    unique case (op_i)
      OP_ADD, OP_CMN: begin x = a_i; y = b_i;  cin = 1'b0; end
      OP_ADC:         begin x = a_i; y = b_i;  cin = c_i;  end
      OP_SUB, OP_CMP: begin x = a_i; y = ~b_i; cin = 1'b1; end
      OP_SBC:         begin x = a_i; y = ~b_i; cin = c_i;  end
      OP_RSB:         begin x = b_i; y = ~a_i; cin = 1'b1; end
      OP_RSC:         begin x = b_i; y = ~a_i; cin = c_i;  end
      default:        begin x = a_i; y = b_i;  cin = 1'b0; end
    endcase
  end

  assign wide   = {1'b0, x} + {1'b0, y} + {{DataW{1'b0}}, cin};
  assign sum_o  = wide[DataW-1:0];
  assign cout_o = wide[DataW];
  assign ovf_o  = (x[MsbIdx] == y[MsbIdx]) && (sum_o[MsbIdx] != x[MsbIdx]);
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned DataW = 32
) (
  input  alu_op_e          op_i,
  input  logic [DataW-1:0] a_i,
  input  logic [DataW-1:0] b_i,
  output logic [DataW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MOV:         res_o = b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic       arith_i,
  input  alu_flags_t nxt_i,
  output alu_flags_t flags_o
);
  alu_flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (upd_i) begin
      flags_q.n <= nxt_i.n;
      flags_q.z <= nxt_i.z;
      flags_q.c <= nxt_i.c;
      if (arith_i) flags_q.v <= nxt_i.v;
    end
  end

  assign flags_o = flags_q;

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_q)); // R9
  AST_V_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !arith_i) |=> $stable(flags_q.v)); // R7
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned DataW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       op_i,
  input  logic [DataW-1:0] a_i,
  input  logic [DataW-1:0] b_i,
  input  logic             sh_carry_i,
  input  logic             set_flags_i,
  output logic [DataW-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);
  localparam int unsigned MsbIdx = DataW - 1;

  alu_op_e          op;
  alu_flags_t       flags_q, flags_nxt;
  logic [DataW-1:0] sum, lres;
  logic             cout, ovf, arith, upd;

  assign op    = alu_op_e'(op_i);
  assign arith = op_is_arith(op);
  assign upd   = set_flags_i | op_is_cmp(op);

  dp_alu_addsub #(.DataW(DataW)) i_addsub (
    .op_i(op), .a_i(a_i), .b_i(b_i), .c_i(flags_q.c),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  dp_alu_logic #(.DataW(DataW)) i_logic (
    .op_i(op), .a_i(a_i), .b_i(b_i), .res_o(lres)
  );

  assign result_o = arith ? sum : lres;
  assign wr_en_o  = !op_is_cmp(op);

  always_comb begin
    flags_nxt.n = result_o[MsbIdx];
    flags_nxt.z = (result_o == '0);
    flags_nxt.c = arith ? cout : sh_carry_i;
    flags_nxt.v = ovf;
  end

  dp_alu_flags i_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .arith_i(arith),
    .nxt_i(flags_nxt), .flags_o(flags_q)
  );

  assign flags_o = flags_q;

  AST_ADD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4) |-> (result_o == a_i + b_i)); // R1
  AST_SUB_NOBORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd2) |-> (cout == (a_i >= b_i))); // R4
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (flags_o[2] == ($past(result_o) == '0))); // R6
  AST_LOGIC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !arith) |=> (flags_o[1] == $past(sh_carry_i))); // R8
endmodule

// File: tb/test_dp_alu.sv
module test_dp_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        shc = 1'b0, setf = 1'b0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags;

  int total = 0, bad = 0;
  logic [3:0] mflags;   // model {N,Z,C,V}

  always #4 clk = ~clk;

  dp_alu i_dp_alu (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .sh_carry_i(shc), .set_flags_i(setf),
    .result_o(result), .wr_en_o(wr_en), .flags_o(flags)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s op=%0d act=%h exp=%h", req, op, act, exp);
    end
  endtask

  // independent reference
  task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic c, output logic [31:0] r, output logic co,
                       output logic v, output logic ar);
    logic [32:0] w;
    logic nb;
    nb = !c;
    ar = 1'b1; co = 1'b0; v = 1'b0; r = '0;
    case (o)
      4'd4, 4'd11: begin w = {1'b0,x} + {1'b0,y}; r = w[31:0]; co = w[32];
                         v = (x[31] == y[31]) && (r[31] != x[31]); end
      4'd5: begin w = {1'b0,x} + {1'b0,y} + {32'd0,c}; r = w[31:0]; co = w[32];
                  v = (x[31] == y[31]) && (r[31] != x[31]); end
      4'd2, 4'd10: begin r = x - y; co = (x >= y);
                         v = (x[31] != y[31]) && (r[31] != x[31]); end
      4'd6: begin r = x - y - {31'd0,nb}; co = ({1'b0,x} >= {1'b0,y} + {32'd0,nb});
                  v = (x[31] != y[31]) && (r[31] != x[31]); end
      4'd3: begin r = y - x; co = (y >= x);
                  v = (y[31] != x[31]) && (r[31] != y[31]); end
      4'd7: begin r = y - x - {31'd0,nb}; co = ({1'b0,y} >= {1'b0,x} + {32'd0,nb});
                  v = (y[31] != x[31]) && (r[31] != y[31]); end
      default: begin
        ar = 1'b0;
        case (o)
          4'd0, 4'd8: r = x & y;
          4'd1, 4'd9: r = x ^ y;
          4'd12: r = x | y;
          4'd14: r = x & ~y;
          4'd13: r = y;
          default: r = ~y;
        endcase
      end
    endcase
  endtask

  function automatic string req_of(logic [3:0] o);
    case (o)
      4'd4, 4'd5: return "R1";
      4'd2, 4'd6: return "R2";
      4'd3, 4'd7: return "R3";
      4'd8, 4'd9, 4'd10, 4'd11: return "R10";
      default: return "R5";
    endcase
  endfunction

  task automatic step(logic [3:0] o, logic [31:0] x, logic [31:0] y, logic s, logic sc);
    logic [31:0] r;
    logic co, v, ar, upd;
    @(negedge clk);
    op = o; a = x; b = y; setf = s; shc = sc;
    #1;
    model(o, x, y, mflags[1], r, co, v, ar);
    check(req_of(o), result, r);
    check("R10 wr_en", {31'd0, wr_en}, {31'd0, !(o >= 4'd8 && o <= 4'd11)});
    upd = s || (o >= 4'd8 && o <= 4'd11);
    if (upd) mflags = {r[31], r == 32'd0, ar ? co : sc, ar ? v : mflags[0]};
    @(posedge clk); #1;
    if (!upd) check("R9 hold", {28'd0, flags}, {28'd0, mflags});
    else if (ar) check("R4/R6/R7 flags", {28'd0, flags}, {28'd0, mflags});
    else check("R8/R6/R7 flags", {28'd0, flags}, {28'd0, mflags});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] wa, wb, ws;
    void'($urandom(32'h5EED_0042));
    mflags = 4'h0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset flags", {28'd0, flags}, 32'd0);
    rst_n = 1'b1;
    // R11 also: ADC right after reset uses C=0
    step(4'd5, 32'd7, 32'd9, 1'b0, 1'b0);
    // R4 borrow edge: equal operands give C=1, Z=1
    step(4'd2, 32'd5, 32'd5, 1'b1, 1'b0);
    step(4'd6, 32'd3, 32'd4, 1'b1, 1'b0);        // R2 borrow -> C=0
    step(4'd7, 32'd1, 32'd1, 1'b1, 1'b1);        // R3 with C=0
    step(4'd4, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b0); // R7 overflow
    step(4'd13, 32'd0, 32'd0, 1'b1, 1'b1);        // R7 V kept, R8 C=shc
    step(4'd10, 32'd1, 32'd2, 1'b0, 1'b0);        // R10 compare with S=0
    step(4'd9, 32'hA5, 32'hA5, 1'b0, 1'b1);       // R10 test-equivalence
    step(4'd12, 32'h0, 32'h8000_0000, 1'b0, 1'b0); // R9 no update
    // R1 128-bit add chain through stored carry
    wa = {32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    wb = {32'h0000_0001, 32'hEDCB_A987, 32'h0000_0000, 32'h0000_0001};
    ws = wa + wb;
    step(4'd4, wa[31:0], wb[31:0], 1'b1, 1'b0);
    check("R1 chain w0", result, ws[31:0]);
    step(4'd5, wa[63:32], wb[63:32], 1'b1, 1'b0);
    check("R1 chain w1", result, ws[63:32]);
    step(4'd5, wa[95:64], wb[95:64], 1'b1, 1'b0);
    check("R1 chain w2", result, ws[95:64]);
    step(4'd5, wa[127:96], wb[127:96], 1'b1, 1'b0);
    check("R1 chain w3", result, ws[127:96]);
    for (int i = 0; i < 3000; i++)
      step(4'($urandom), pick(), pick(), 1'($urandom), 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule